// File: doc/BRIEF.md
# Signed Dadda-Tree Multiplier

This block multiplies two signed N-bit operands. Every bit product is formed at once. The products whose row or column is the operand sign bit, but not both, are inverted, and one fixed one is added at weight 2^N. That fixed bit is the correction that makes a plain unsigned summation produce the two's complement result. The resulting dot matrix is reduced to two rows by a chain of adder stages. The stage heights follow the Dadda limits 2, 3, 4, 6, 9, 13, 19, and so on. In each limit sequence, a term is the largest integer no greater than one and a half times the term before it. A stage reduces only the columns that would otherwise exceed its limit, and it uses the fewest full and half adders that achieve this. A single carry-propagate adder sums the two remaining rows.

The number of stages and every adder in them are worked out from N while the design elaborates, so one source serves 5-, 8- and 16-bit operands. A round input adds a dot of weight 2^(N-2) to the matrix. With the round input low, the output is the exact product in 2N-1 bits. With it high, the output is the upper N bits of the sum, rounded to nearest, sign-extended to the output width. The output can be registered once (parameter `OUT_REG`). The output cannot represent the most negative operand squared, so the system must never present that pair.

Top module: `dadda_mul`

## Requirements
- R1: With `rnd`=0, `y` equals the signed product `op_a`×`op_b` in 2N-1 bits, for every operand pair except both operands equal to -2^(N-1).
- R2: With `rnd`=1, `y` equals floor((`op_a`×`op_b` + 2^(N-2)) / 2^(N-1)). This is an N-bit signed value, sign-extended to 2N-1 bits.
- R3: If either operand is zero, `y` is zero in both modes.
- R4: With `rnd`=0 and both operands nonzero, the top bit of `y` is the XOR of the two operand sign bits.
- R5: With `OUT_REG`=1, `y` shows the result for the inputs sampled at the previous rising edge of `clk`. It holds that value until the next rising edge.
- R6: While `rst_n` is low, `y` is zero. The reset is asynchronous, active low.
- R7: Each reduction stage leaves the weighted sum of the matrix unchanged (modulo 2^(2N-1)). No column of a stage's output is taller than that stage's Dadda limit. The final matrix has at most two dots per column.
- R8: The modified bit-product matrix has a weighted sum equal to `op_a`×`op_b` + `rnd`·2^(N-2), modulo 2^(2N-1).
- R9: A rounding tie, where the discarded part is exactly half of one output LSB, rounds toward plus infinity. For example, with N=5, 2×4 gives 1 and -2×4 gives 0.
- R10: Products that use the extreme operands are exact: -2^(N-1) times 2^(N-1)-1, the largest positive value squared, and -2^(N-1) times -(2^(N-1)-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | N | Signed multiplicand |
| op_b | input | N | Signed multiplier |
| rnd | input | 1 | 1: rounded N-bit result; 0: full-width result |
| y | output | 2N-1 | Product, full or rounded and sign-extended |

## Verification
The bench targets the sign-row and sign-column inversions and the fixed correction one. If either is wrong, every mixed-sign product, or every product with a negative operand, comes out wrong. The exhaustive 5-bit sweep exposes this at once, together with the extreme operands -16×15 and 15×15. The rounding dot is probed at exact ties. A dot placed one column off, or left out of the matrix, shows up as halves that round the wrong way, or as no rounding at all. A second, 16-bit instance runs on random operands, which catches a schedule that is right only for a short matrix. Examples are an adder count that drops a carry, or a stage taller than its limit. A reset pulse during the run checks that the output register clears without waiting for a clock edge.

// File: rtl/dadda_pkg.sv
package dadda_pkg;

    // Upper bound on matrix columns handled by the schedule functions.
    localparam int DD_MAXC = 130;

    // k-th term of the Dadda height sequence, k starting at 1 (2, 3, 4, 6, 9, ...).
    function automatic int dd_limit(input int k);
        int d;
        d = 2;
        for (int i = 1; i < k; i++) d = (d * 3) / 2;
        return d;
    endfunction

    // Number of reduction stages for an n-row matrix.
    function automatic int dd_nstages(input int n);
        int k;
        k = 0;
        while (dd_limit(k + 1) < n) k++;
        return k;
    endfunction

    // Dots in column c of the initial signed matrix, including the
    // fixed correction one (column n) and the rounding dot (column n-2).
    function automatic int dd_init_h(input int n, input int c);
        int lo, hi, cnt;
        lo  = (c > n - 1) ? c - n + 1 : 0;
        hi  = (c < n - 1) ? c : n - 1;
        cnt = (hi >= lo) ? hi - lo + 1 : 0;
        if (c == n)     cnt++;
        if (c == n - 2) cnt++;
        return cnt;
    endfunction

    // Schedule query for stage s, column c.
    // what: 0 = dots entering, 1 = full adders, 2 = half adders,
    //       3 = carries arriving from column c-1 within the stage.
    function automatic int dd_info(input int n, input int s, input int c, input int what);
        int h  [DD_MAXC];
        int nh [DD_MAXC];
        int nst, cols, cin, tgt, hv, f, ha;
        nst  = dd_nstages(n);
        cols = 2 * n - 1;
        for (int col = 0; col < DD_MAXC; col++) begin
            h[col]  = (col < cols) ? dd_init_h(n, col) : 0;
            nh[col] = 0;
        end
        for (int t = 0; t <= s; t++) begin
            tgt = (t < nst) ? dd_limit(nst - t) : (1 << 20);
            cin = 0;
            for (int col = 0; col < cols; col++) begin
                hv = h[col];
                f  = 0;
                ha = 0;
                if (hv + cin > tgt) begin
                    f  = (hv + cin - tgt) / 2;
                    ha = (hv + cin - tgt) % 2;
                end
                if (t == s && col == c) begin
                    case (what)
                        0:       return hv;
                        1:       return f;
                        2:       return ha;
                        default: return cin;
                    endcase
                end
                nh[col] = hv + cin - 2 * f - ha;
                cin     = f + ha;
            end
            for (int col = 0; col < cols; col++) h[col] = nh[col];
        end
        return 0;
    endfunction

endpackage

// File: rtl/dadda_ppgen.sv
module dadda_ppgen
    import dadda_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]               op_a,
    input  logic [N-1:0]               op_b,
    input  logic                       rnd,
    output logic [(2*N-1)*N-1:0]       mat
);
    localparam int COLS = 2 * N - 1;
    localparam int MAXH = N;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        localparam int LO = (c > N - 1) ? c - N + 1 : 0;
        localparam int HI = (c < N - 1) ? c : N - 1;
        localparam int NP = HI - LO + 1;
        for (genvar k = 0; k < MAXH; k++) begin : g_slot
            if (k < NP) begin : g_pp
                localparam int RI = LO + k;     // row: bit of op_b
                localparam int CJ = c - RI;     // bit of op_a
                if ((RI == N - 1) != (CJ == N - 1)) begin : g_inv
                    assign mat[c*MAXH+k] = ~(op_a[CJ] & op_b[RI]);
                end else begin : g_pos
                    assign mat[c*MAXH+k] = op_a[CJ] & op_b[RI];
                end
            end else if (c == N && k == NP) begin : g_one
                assign mat[c*MAXH+k] = 1'b1;
            end else if (c == N - 2 && k == NP) begin : g_rnd
                assign mat[c*MAXH+k] = rnd;
            end else begin : g_zero
                assign mat[c*MAXH+k] = 1'b0;
            end
        end
    end

    // Weighted matrix sum must match the signed product plus rounding dot.
    logic signed [2*N-1:0] chk_prod;
    logic [COLS-1:0]       chk_sum;
    logic [COLS-1:0]       chk_exp;
    always_comb begin
        chk_prod = $signed(op_a) * $signed(op_b);
        chk_exp  = chk_prod[COLS-1:0] + (COLS'(rnd) << (N - 2));
        chk_sum  = '0;
        for (int c = 0; c < COLS; c++)
            for (int k = 0; k < MAXH; k++)
                chk_sum = chk_sum + (COLS'(mat[c*MAXH+k]) << c);
        AST_MATRIX_VALUE: assert (chk_sum == chk_exp) else $error("matrix sum mismatch"); // R8
    end

endmodule

// File: rtl/dadda_stage.sv
module dadda_stage
    import dadda_pkg::*;
#(
    parameter int N = 8,
    parameter int S = 0
) (
    input  logic [(2*N-1)*N-1:0] m_in,
    output logic [(2*N-1)*N-1:0] m_out
);
    localparam int COLS = 2 * N - 1;
    localparam int MAXH = N;
    localparam int LIM  = dd_limit(dd_nstages(N) - S);

    logic [COLS*MAXH-1:0] cy;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        localparam int H  = dd_info(N, S, c, 0);
        localparam int F  = dd_info(N, S, c, 1);
        localparam int HA = dd_info(N, S, c, 2);
        localparam int CI = dd_info(N, S, c, 3);
        localparam int PS = H - 3 * F - 2 * HA;
        localparam int D  = F + HA + PS + CI;
        localparam int B  = c * MAXH;

        for (genvar k = 0; k < F; k++) begin : g_fa
            assign m_out[B+k] = m_in[B+3*k] ^ m_in[B+3*k+1] ^ m_in[B+3*k+2];
            assign cy[B+k]    = (m_in[B+3*k] & m_in[B+3*k+1])
                              | (m_in[B+3*k] & m_in[B+3*k+2])
                              | (m_in[B+3*k+1] & m_in[B+3*k+2]);
        end
        for (genvar k = 0; k < HA; k++) begin : g_ha
            assign m_out[B+F+k] = m_in[B+3*F+2*k] ^ m_in[B+3*F+2*k+1];
            assign cy[B+F+k]    = m_in[B+3*F+2*k] & m_in[B+3*F+2*k+1];
        end
        for (genvar k = 0; k < PS; k++) begin : g_pass
            assign m_out[B+F+HA+k] = m_in[B+3*F+2*HA+k];
        end
        if (c > 0) begin : g_cin
            for (genvar k = 0; k < CI; k++) begin : g_c
                assign m_out[B+F+HA+PS+k] = cy[B-MAXH+k];
            end
        end
        for (genvar k = D; k < MAXH; k++) begin : g_zo
            assign m_out[B+k] = 1'b0;
        end
        for (genvar k = F + HA; k < MAXH; k++) begin : g_zc
            assign cy[B+k] = 1'b0;
        end
    end

    logic unused_cy;
    assign unused_cy = ^cy;

    logic [COLS-1:0] sum_in;
    logic [COLS-1:0] sum_out;
    always_comb begin
        sum_in  = '0;
        sum_out = '0;
        for (int c = 0; c < COLS; c++)
            for (int k = 0; k < MAXH; k++) begin
                sum_in  = sum_in  + (COLS'(m_in[c*MAXH+k])  << c);
                sum_out = sum_out + (COLS'(m_out[c*MAXH+k]) << c);
            end
        AST_STAGE_VALUE: assert (sum_in == sum_out) else $error("stage %0d changed value", S); // R7
        for (int c = 0; c < COLS; c++) begin
            AST_STAGE_HEIGHT: assert ((m_out[c*MAXH +: MAXH] >> LIM) == '0)
                else $error("stage %0d column %0d above limit", S, c); // R7
        end
    end

endmodule

// File: rtl/dadda_cpa.sv
module dadda_cpa #(
    parameter int N = 8
) (
    input  logic [(2*N-1)*N-1:0] m_fin,
    output logic [2*N-2:0]       sum
);
    localparam int COLS = 2 * N - 1;
    localparam int MAXH = N;

    logic [COLS-1:0] row0;
    logic [COLS-1:0] row1;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign row0[c] = m_fin[c*MAXH];
        assign row1[c] = m_fin[c*MAXH+1];
    end

    assign sum = row0 + row1;

    logic unused_hi;
    assign unused_hi = ^m_fin;

    always_comb begin
        for (int c = 0; c < COLS; c++) begin
            AST_TWO_ROWS: assert ((m_fin[c*MAXH +: MAXH] >> 2) == '0)
                else $error("column %0d has more than two dots", c); // R7
        end
    end

endmodule

// File: rtl/dadda_mul.sv
module dadda_mul
    import dadda_pkg::*;
#(
    parameter int N       = 8,
    parameter int OUT_REG = 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   op_a,
    input  logic [N-1:0]   op_b,
    input  logic           rnd,
    output logic [2*N-2:0] y
);
    localparam int W    = 2 * N - 1;
    localparam int MAXH = N;
    localparam int NST  = dd_nstages(N);
    localparam logic [N-1:0] MINV = {1'b1, {(N-1){1'b0}}};

    logic [W*MAXH-1:0] mat [NST+1];
    logic [W-1:0]      sum;
    logic [W-1:0]      y_d;

    dadda_ppgen #(.N(N)) u_pp (
        .op_a (op_a),
        .op_b (op_b),
        .rnd  (rnd),
        .mat  (mat[0])
    );

    for (genvar s = 0; s < NST; s++) begin : g_stage
        dadda_stage #(.N(N), .S(s)) u_st (
            .m_in  (mat[s]),
            .m_out (mat[s+1])
        );
    end

    dadda_cpa #(.N(N)) u_cpa (
        .m_fin (mat[NST]),
        .sum   (sum)
    );

    assign y_d = rnd ? {{(N-1){sum[W-1]}}, sum[W-1:N-1]} : sum;

    if (OUT_REG != 0) begin : g_reg
        logic [W-1:0] y_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) y_q <= '0;
            else        y_q <= y_d;
        end
        assign y = y_q;

        AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && ($past(op_a) == '0 || $past(op_b) == '0)) |-> (y == '0))
            else $error("zero operand gave nonzero result"); // R3

        AST_SIGN_RULE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(rnd) && $past(op_a) != '0 && $past(op_b) != '0
             && !($past(op_a) == MINV && $past(op_b) == MINV))
            |-> (y[W-1] == ($past(op_a[N-1]) ^ $past(op_b[N-1]))))
            else $error("product sign wrong"); // R4
    end else begin : g_comb
        assign y = y_d;
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
    end

endmodule

// File: tb/sim_dadda_mul.sv
module sim_dadda_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  a5 = '0, b5 = '0;
    logic        r5 = 1'b0;
    logic [15:0] a16 = '0, b16 = '0;
    logic        r16 = 1'b0;
    logic [8:0]  y5;
    logic [30:0] y16;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    longint q5[$];
    longint q16[$];
    string  qt5[$];
    string  qt16[$];

    always #10 clk = ~clk;   // 50 MHz

    dadda_mul #(.N(5), .OUT_REG(1)) u0 (
        .clk(clk), .rst_n(rst_n), .op_a(a5), .op_b(b5), .rnd(r5), .y(y5));
    dadda_mul #(.N(16), .OUT_REG(1)) u1 (
        .clk(clk), .rst_n(rst_n), .op_a(a16), .op_b(b16), .rnd(r16), .y(y16));

    function automatic longint ref_y(input longint a, input longint b, input logic r, input int n);
        longint p;
        p = a * b;
        if (r) p = (p + (longint'(1) << (n - 2))) >>> (n - 1);
        return p;
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp, input int w);
        longint m;
        m = (longint'(1) << w) - 1;
        checks++;
        if ((act & m) != (exp & m)) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act & m, exp & m);
        end
    endtask

    task automatic compare();
        if (q5.size() != 0) chk(qt5.pop_front(), longint'(y5), q5.pop_front(), 9);
        if (q16.size() != 0) chk(qt16.pop_front(), longint'(y16), q16.pop_front(), 31);
    endtask

    task automatic step(input logic [4:0] ia, input logic [4:0] ib, input logic ir,
                        input logic [15:0] ja, input logic [15:0] jb, input logic jr,
                        input string t5, input string t16);
        @(negedge clk);
        compare();
        a5 = ia; b5 = ib; r5 = ir;
        a16 = ja; b16 = jb; r16 = jr;
        q5.push_back(ref_y(longint'($signed(ia)), longint'($signed(ib)), ir, 5));
        qt5.push_back(t5);
        q16.push_back(ref_y(longint'($signed(ja)), longint'($signed(jb)), jr, 16));
        qt16.push_back(t16);
    endtask

    function automatic string mode_tag(input logic r);
        return r ? "R2 R7 R8" : "R1 R7 R8";
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] ra, rb;
        logic        rr;
        repeat (3) @(negedge clk);
        #1;
        chk("R6 reset u0", longint'(y5), 0, 9);
        chk("R6 reset u1", longint'(y16), 0, 31);
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive 5-bit sweep, both modes; u1 on random operands.
        for (int ia = 0; ia < 32; ia++) begin
            for (int ib = 0; ib < 32; ib++) begin
                for (int ir = 0; ir < 2; ir++) begin
                    if (ia == 16 && ib == 16) continue;
                    ra = 16'($urandom); rb = 16'($urandom); rr = 1'($urandom);
                    if (ra == 16'h8000 && rb == 16'h8000) rb = 16'h8001;
                    step(5'(ia), 5'(ib), 1'(ir), ra, rb, rr, mode_tag(1'(ir)), mode_tag(rr));
                end
            end
        end

        // R3: zero operands, both modes.
        step(5'd0, 5'd13, 1'b0, 16'h0000, 16'h8000, 1'b0, "R3", "R3");
        step(5'd16, 5'd0, 1'b1, 16'h7fff, 16'h0000, 1'b1, "R3", "R3");
        // R4: mixed signs.
        step(5'h1d, 5'd5, 1'b0, 16'hfff3, 16'h0101, 1'b0, "R4", "R4");
        step(5'd7, 5'h19, 1'b0, 16'h1234, 16'hedcc, 1'b0, "R4", "R4");
        // R9: exact rounding ties, positive and negative.
        step(5'd2, 5'd4, 1'b1, 16'h0080, 16'h0080, 1'b1, "R9", "R9");
        step(5'h1e, 5'd4, 1'b1, 16'hff80, 16'h0080, 1'b1, "R9", "R9");
        // R10: extreme operands.
        step(5'h10, 5'h0f, 1'b0, 16'h8000, 16'h7fff, 1'b0, "R10", "R10");
        step(5'h0f, 5'h0f, 1'b0, 16'h7fff, 16'h7fff, 1'b0, "R10", "R10");
        step(5'h10, 5'h11, 1'b0, 16'h8000, 16'h8001, 1'b0, "R10", "R10");
        step(5'h10, 5'h0f, 1'b1, 16'h8000, 16'h7fff, 1'b1, "R10", "R10");
        // R5: a new operand right after a different result.
        step(5'd7, 5'd7, 1'b0, 16'h0007, 16'h0007, 1'b0, "R5", "R5");
        step(5'h19, 5'd7, 1'b0, 16'hfff9, 16'h0007, 1'b0, "R5", "R5");

        // Random phase on both instances.
        for (int n = 0; n < 20000; n++) begin
            logic [4:0] sa, sb;
            logic       sr;
            sa = 5'($urandom); sb = 5'($urandom); sr = 1'($urandom);
            if (sa == 5'h10 && sb == 5'h10) sb = 5'h11;
            ra = 16'($urandom); rb = 16'($urandom); rr = 1'($urandom);
            if (ra == 16'h8000 && rb == 16'h8000) rb = 16'h8001;
            step(sa, sb, sr, ra, rb, rr, mode_tag(sr), mode_tag(rr));
        end

        // Drain, then R6: asynchronous reset mid-run clears a nonzero output.
        step(5'd9, 5'd9, 1'b0, 16'h0333, 16'h0101, 1'b0, "R1", "R1");
        @(negedge clk);
        compare();
        rst_n = 1'b0;
        #1;
        chk("R6 async clear u0", longint'(y5), 0, 9);
        chk("R6 async clear u1", longint'(y16), 0, 31);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule